// File: doc/BRIEF.md
# Sync Polarity and Presence Processor

This block conditions the two sync inputs of a deflection controller. One input carries horizontal sync or composite horizontal/vertical sync. The other carries vertical-only sync. Each input passes through a clock-domain synchroniser. It then gets a polarity detector and an inverter. The inverter makes the active pulse of every signal leaving the block high. Users set the inverter per input: it can follow the detector or take a fixed setting.

The normalised first input drives the horizontal sync output. It also drives an integrating extractor that recovers vertical pulses from composite sync. A select bit picks the vertical sync output from two sources: the extractor or the normalised second input. Presence detectors watch both inputs and the extractor output. The presence and polarity results are five status flags for a status register. All of them change only at the end of a programmable measurement window.

Top module: `sync_polarity_presence`

## Requirements
- R1: Each input passes through two synchronising flops. `h_sync_out` follows a change on `h_sync_in` exactly 3 clock edges later. With `v_src_ext`=0, `v_sync_out` follows a change on `v_sync_in` exactly 4 edges later.
- R2: Over each window, the polarity detector counts the cycles an input spends high and the cycles it spends low. A polarity flag (`h_pol_neg`, `v_pol_neg`) of 1 means negative polarity. The flag becomes 1 when high time exceeded low time. It becomes 0 when low time exceeded high time. On a tie it is unchanged.
- R3: With the auto bit at 1, the inverter uses the detected polarity. With the auto bit at 0, the inverter uses the manual bit, where 1 means invert. The polarity flag keeps reporting what was detected.
- R4: A presence flag becomes 1 at the end of a window that contained at least one edge of its signal. It becomes 0 at the end of a window that contained none.
- R5: A window lasts `win_len` cycles and starts at reset release. Presence and polarity flags change only on the clock edges that close a window, which are multiples of `win_len` edges after reset release.
- R6: The extractor keeps a saturating up/down counter. The counter rises while normalised horizontal sync is high and falls otherwise. The extracted pulse asserts once the counter reaches the upper threshold. Short horizontal pulses never assert it.
- R7: After assertion, the extracted pulse stays high until the counter falls to or below the lower threshold.
- R8: With `v_src_ext`=1, `v_sync_out` carries the extracted pulse and ignores `v_sync_in`. With `v_src_ext`=0, it carries the normalised second input.
- R9: `ext_present` reports presence, under the rule of R4, on the extracted vertical pulse.
- R10: The second input has its own polarity detection, inversion and presence flag (`v_pol_neg`, `v_present`), which work like those of the first input.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| win_len | input | WIN_W | Measurement window length in cycles |
| h_sync_in | input | 1 | Horizontal or composite sync, asynchronous |
| v_sync_in | input | 1 | Vertical-only sync, asynchronous |
| h_pol_auto | input | 1 | First input inverter follows detected polarity |
| h_pol_man | input | 1 | First input manual invert setting |
| v_pol_auto | input | 1 | Second input inverter follows detected polarity |
| v_pol_man | input | 1 | Second input manual invert setting |
| v_src_ext | input | 1 | 1 selects the extractor as the vertical source |
| h_sync_out | output | 1 | Normalised horizontal sync, active high |
| v_sync_out | output | 1 | Selected vertical sync, active high |
| h_present | output | 1 | Activity seen on first input |
| v_present | output | 1 | Activity seen on second input |
| ext_present | output | 1 | Activity seen on extracted vertical pulse |
| h_pol_neg | output | 1 | First input detected as negative polarity |
| v_pol_neg | output | 1 | Second input detected as negative polarity |

## Verification
The bench builds the block with a 10-bit window width and a 6-bit extractor counter, with thresholds of 40 and 8. It drives a 200-cycle window. With these values the test reaches several window ends, a saturated extractor counter and a full hysteresis discharge, all within a few thousand cycles. A horizontal pulse of 4 cycles in a 20-cycle period stays far below the upper threshold. A 100-cycle composite vertical pulse crosses it, which separates the two cases clearly.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef struct packed {
    logic h_present;
    logic v_present;
    logic ext_present;
    logic h_pol_neg;
    logic v_pol_neg;
  } sp_status_t;

  localparam int SP_NUM_CH = 2;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_window.sv
module sp_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] cnt;
  logic [WIN_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign win_end  = (cnt_next >= {1'b0, win_len});

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt_next[WIN_W-1:0];
  end

  AST_WIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (cnt == '0)) else $error("window counter did not wrap"); // R5
endmodule

// File: rtl/sp_presence.sv
module sp_presence (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic win_end,
  output logic present
);
  logic sig_d;
  logic seen;
  logic edge_now;

  assign edge_now = sig ^ sig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_d   <= 1'b0;
      seen    <= 1'b0;
      present <= 1'b0;
    end else begin
      sig_d <= sig;
      if (win_end) begin
        present <= seen | edge_now;
        seen    <= 1'b0;
      end else if (edge_now) begin
        seen <= 1'b1;
      end
    end
  end

  AST_DET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(present)) else $error("presence moved mid-window"); // R5
endmodule

// File: rtl/sp_vextract.sv
module sp_vextract #(
  parameter int CNT_W = 10,
  parameter int HI_TH = 768,
  parameter int LO_TH = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic hs,
  output logic vs
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HI_V    = CNT_W'(HI_TH);
  localparam logic [CNT_W-1:0] LO_V    = CNT_W'(LO_TH);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (hs) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              vs <= 1'b0;
    else if (cnt >= HI_V) vs <= 1'b1;
    else if (cnt <= LO_V) vs <= 1'b0;
  end

  AST_EXT_STEP: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} == {1'b0, $past(cnt)}) ||
    ({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
    ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})) else $error("counter jumped"); // R6
  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!vs && cnt < HI_V) |=> !vs) else $error("pulse rose below threshold"); // R6
  AST_EXT_HYST: assert property (@(posedge clk) disable iff (rst)
    (vs && cnt > LO_V) |=> vs) else $error("pulse fell above low threshold"); // R7
endmodule

// File: rtl/sp_channel.sv
module sp_channel #(
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  input  logic win_end,
  input  logic pol_auto,
  input  logic pol_man,
  output logic norm,
  output logic present,
  output logic pol_neg
);
  localparam logic [WIN_W-1:0] SAT = '1;

  logic             s;
  logic [WIN_W-1:0] hi_cnt;
  logic [WIN_W-1:0] lo_cnt;
  logic             inv;

  sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      pol_neg <= 1'b0;
    end else if (win_end) begin
      if (hi_cnt > lo_cnt)      pol_neg <= 1'b1;
      else if (lo_cnt > hi_cnt) pol_neg <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (s) begin
      if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign inv = pol_auto ? pol_neg : pol_man;

  always_ff @(posedge clk) begin
    if (rst) norm <= 1'b0;
    else     norm <= s ^ inv;
  end

  sp_presence u_pres (
    .clk(clk), .rst(rst), .sig(s), .win_end(win_end), .present(present)
  );

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(pol_neg)) else $error("polarity moved mid-window"); // R5
endmodule

// File: rtl/sync_polarity_presence.sv
module sync_polarity_presence #(
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_W       = 10,
  parameter int EXT_HI      = 768,
  parameter int EXT_LO      = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  input  logic             h_sync_in,
  input  logic             v_sync_in,
  input  logic             h_pol_auto,
  input  logic             h_pol_man,
  input  logic             v_pol_auto,
  input  logic             v_pol_man,
  input  logic             v_src_ext,
  output logic             h_sync_out,
  output logic             v_sync_out,
  output logic             h_present,
  output logic             v_present,
  output logic             ext_present,
  output logic             h_pol_neg,
  output logic             v_pol_neg
);
  import sp_pkg::*;

  logic                 win_end;
  logic [SP_NUM_CH-1:0] ch_raw, ch_auto, ch_man, ch_norm, ch_pres, ch_neg;
  logic                 ext_vs;
  logic                 ext_pres;
  sp_status_t           status;

  assign ch_raw  = {v_sync_in,  h_sync_in};
  assign ch_auto = {v_pol_auto, h_pol_auto};
  assign ch_man  = {v_pol_man,  h_pol_man};

  sp_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .win_len(win_len), .win_end(win_end)
  );

  generate
    for (genvar i = 0; i < SP_NUM_CH; i++) begin : g_ch
      sp_channel #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk(clk), .rst(rst), .raw_in(ch_raw[i]), .win_end(win_end),
        .pol_auto(ch_auto[i]), .pol_man(ch_man[i]),
        .norm(ch_norm[i]), .present(ch_pres[i]), .pol_neg(ch_neg[i])
      );
    end
  endgenerate

  sp_vextract #(.CNT_W(EXT_W), .HI_TH(EXT_HI), .LO_TH(EXT_LO)) u_ext (
    .clk(clk), .rst(rst), .hs(ch_norm[0]), .vs(ext_vs)
  );

  sp_presence u_ext_pres (
    .clk(clk), .rst(rst), .sig(ext_vs), .win_end(win_end), .present(ext_pres)
  );

  always_ff @(posedge clk) begin
    if (rst) v_sync_out <= 1'b0;
    else     v_sync_out <= v_src_ext ? ext_vs : ch_norm[1];
  end

  assign status.h_present   = ch_pres[0];
  assign status.v_present   = ch_pres[1];
  assign status.ext_present = ext_pres;
  assign status.h_pol_neg   = ch_neg[0];
  assign status.v_pol_neg   = ch_neg[1];

  assign h_sync_out  = ch_norm[0];
  assign h_present   = status.h_present;
  assign v_present   = status.v_present;
  assign ext_present = status.ext_present;
  assign h_pol_neg   = status.h_pol_neg;
  assign v_pol_neg   = status.v_pol_neg;

  AST_VSRC_EXT: assert property (@(posedge clk) disable iff (rst)
    v_src_ext |=> (v_sync_out == $past(ext_vs))) else $error("vertical source wrong"); // R8
  AST_FLAGS_WIN: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(status)) else $error("status moved mid-window"); // R5
endmodule

// File: tb/tb_sync_polarity_presence.sv
module tb_sync_polarity_presence;
  localparam int WIN_W = 10;
  localparam int WIN   = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIN_W-1:0] win_len = WIN_W'(WIN);
  logic h_in = 1'b0, v_in = 1'b0;
  logic h_auto = 1'b1, h_man = 1'b0, v_auto = 1'b1, v_man = 1'b0, v_ext = 1'b0;
  logic h_out, v_out, h_pres, v_pres, e_pres, h_neg, v_neg;

  int total = 0;
  int bad   = 0;
  int edges = 0;
  int r5_viol = 0;
  logic [4:0] flags_prev = '0;
  bit finished = 0;

  always #4ns clk = ~clk;

  sync_polarity_presence #(
    .WIN_W(WIN_W), .SYNC_STAGES(2), .EXT_W(6), .EXT_HI(40), .EXT_LO(8)
  ) dut (
    .clk(clk), .rst(rst), .win_len(win_len), .h_sync_in(h_in), .v_sync_in(v_in),
    .h_pol_auto(h_auto), .h_pol_man(h_man), .v_pol_auto(v_auto), .v_pol_man(v_man),
    .v_src_ext(v_ext), .h_sync_out(h_out), .v_sync_out(v_out),
    .h_present(h_pres), .v_present(v_pres), .ext_present(e_pres),
    .h_pol_neg(h_neg), .v_pol_neg(v_neg)
  );

  always @(posedge clk) if (!rst) edges <= edges + 1;

  // R5 monitor: flags may only change on edges that close a window
  always @(negedge clk) begin
    if (!rst) begin
      if ({h_pres, v_pres, e_pres, h_neg, v_neg} != flags_prev && (edges % WIN) != 0)
        r5_viol++;
      flags_prev <= {h_pres, v_pres, e_pres, h_neg, v_neg};
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input bit on_v, input bit act_low, input int period,
                        input int width, input int count);
    for (int p = 0; p < count; p++)
      for (int c = 0; c < period; c++) begin
        @(negedge clk);
        if (on_v) v_in = (c < width) ^ act_low;
        else      h_in = (c < width) ^ act_low;
      end
  endtask

  task automatic wait_flag(ref logic f, input bit val, input int maxc, output bit hit);
    hit = 0;
    for (int i = 0; i < maxc && !hit; i++) begin
      @(negedge clk);
      if (f == val) hit = 1;
    end
  endtask

  task automatic t_reset();
    check(h_out == 0 && v_out == 0, "R11", "sync outputs after reset", {h_out, v_out}, 0);
    check({h_pres, v_pres, e_pres, h_neg, v_neg} == 0, "R11", "flags after reset",
          {h_pres, v_pres, e_pres, h_neg, v_neg}, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); h_in = 1; v_in = 1;
    cyc(2); check(h_out == 0, "R1", "h_sync_out after 2 edges", h_out, 0);
    cyc(1); check(h_out == 1, "R1", "h_sync_out after 3 edges", h_out, 1);
    check(v_out == 0, "R1", "v_sync_out after 3 edges", v_out, 0);
    cyc(1); check(v_out == 1, "R1", "v_sync_out after 4 edges", v_out, 1);
    h_in = 0; v_in = 0;
    cyc(8);
  endtask

  task automatic t_h_positive();
    v_ext = 1;
    pulses(0, 0, 20, 4, 25);
    check(h_neg == 0, "R2", "positive h polarity", h_neg, 0);
    check(h_pres == 1, "R4", "h presence with pulses", h_pres, 1);
    check(v_out == 0, "R6", "no extracted pulse from short h", v_out, 0);
    check(e_pres == 0, "R9", "no extractor activity", e_pres, 0);
    h_in = 0;
    cyc(20);
    check(h_pres == 1, "R5", "h presence held mid-window", h_pres, 1);
    cyc(430);
    check(h_pres == 0, "R4", "h presence cleared after silent window", h_pres, 0);
  endtask

  task automatic t_h_negative();
    pulses(0, 1, 20, 4, 25);
    check(h_neg == 1, "R2", "negative h polarity", h_neg, 1);
    h_in = 1; cyc(5);
    check(h_out == 0, "R2", "idle high inverted to low", h_out, 0);
    h_in = 0; cyc(5);
    check(h_out == 1, "R2", "active low inverted to high", h_out, 1);
    h_in = 1; cyc(5);
  endtask

  task automatic t_manual();
    h_auto = 0; h_man = 0; cyc(5);
    check(h_out == 1, "R3", "manual no-invert passes level", h_out, 1);
    h_man = 1; cyc(5);
    check(h_out == 0, "R3", "manual invert", h_out, 0);
    check(h_neg == 1, "R3", "flag keeps detected polarity", h_neg, 1);
    h_man = 0;
  endtask

  task automatic t_extract();
    bit hit;
    v_ext = 1; h_in = 0; cyc(100);
    h_in = 1; cyc(30);
    check(v_out == 0, "R6", "below upper threshold", v_out, 0);
    cyc(70);
    check(v_out == 1, "R6", "long pulse extracted", v_out, 1);
    v_in = 1; cyc(6);
    check(v_out == 1, "R8", "extractor source ignores v_sync_in", v_out, 1);
    v_in = 0;
    h_in = 0; cyc(20);
    check(v_out == 1, "R7", "hysteresis keeps pulse", v_out, 1);
    cyc(80);
    check(v_out == 0, "R7", "pulse released below low threshold", v_out, 0);
    wait_flag(e_pres, 1, 450, hit);
    check(hit, "R9", "extractor presence reported", e_pres, 1);
    v_in = 1; cyc(6);
    check(v_out == 0, "R8", "ext source low while v_sync_in high", v_out, 0);
    v_ext = 0; cyc(2);
    check(v_out == 1, "R8", "second input selected", v_out, 1);
    v_in = 0; cyc(6);
    check(v_out == 0, "R8", "second input follows low", v_out, 0);
  endtask

  task automatic t_v_negative();
    pulses(1, 1, 20, 4, 25);
    check(v_neg == 1, "R10", "negative v polarity", v_neg, 1);
    check(v_pres == 1, "R10", "v presence", v_pres, 1);
    v_in = 0; cyc(6);
    check(v_out == 1, "R10", "v active low inverted to high", v_out, 1);
    v_in = 1; cyc(6);
    check(v_out == 0, "R10", "v idle inverted to low", v_out, 0);
  endtask

  initial begin
    cyc(5);
    rst = 0;
    t_reset();
    t_latency();
    t_h_positive();
    t_h_negative();
    t_manual();
    t_extract();
    t_v_negative();
    check(r5_viol == 0, "R5", "flag changes off window boundary", r5_viol, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1200us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", edges, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule